// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Detection

This block receives asynchronous serial characters on a single input line. A sample-tick input runs at sixteen times the bit rate, and the block takes a three-sample majority vote at the centre of each bit. A character has a start bit, eight or nine data bits sent LSB first, and one or two stop bits. A character that completes cleanly is placed in a holding buffer and flagged as ready. A character whose stop bit reads low is flagged as a framing error, and the buffer keeps what it held before.

For links that mark the start of a message with a long low pulse, a break-detection mode counts consecutive low samples. It raises a sticky break flag once the count reaches a threshold that depends on the character format. While this mode is on, the ready and framing-error flags are held off. An activity flag rises when a start edge is seen. It falls once the line has been high and the receiver idle for one full character time.

Software reads the buffer through a register-style port. The low eight bits and the ninth bit are always visible. A one-cycle read strobe on the data byte ends the read and clears the ready and framing-error flags on the following clock. A new character can then replace both parts of the buffer, so the ninth bit has to be taken before the byte is acknowledged.

Top module: `uart_rx_brk`

## Requirements
- R1: Characters carry 8 data bits (nine_bit=0) or 9 data bits (nine_bit=1), sent LSB first after one low start bit. The first 8 received bits appear on data_out[7:0]. The ninth appears on bit9_out, and bit9_out is 0 for 8-bit characters.
- R2: Each bit is decided by a majority of three samples, taken 6, 7 and 8 sample ticks after the bit's first sample. A single-tick glitch inside a bit does not change the received value. If the vote over the start bit comes out high, the start is rejected as noise, and neither rx_ready nor frame_err sets.
- R3: The character has one stop bit (two_stop=0) or two (two_stop=1). If any stop bit votes low, frame_err sets, rx_ready does not set, and data_out and bit9_out keep their previous values.
- R4: A character with good stop bits sets rx_ready and loads the buffer. A one-cycle pulse on data_rd clears rx_ready and frame_err on the next clock.
- R5: When a character completes while rx_ready is still set and no read is under way, the buffer keeps the old data.
- R6: With brk_det_en=1, brk_flag sets once the line has been low for a run of consecutive sample ticks. The run is 16 times 11 bit times for 8 bits with one stop bit, 16 times 12 bit times for exactly one of nine_bit and two_stop set, and 16 times 13 bit times for both set. Shorter runs leave it clear. With brk_det_en=0, brk_flag never sets.
- R7: brk_flag is sticky until brk_clr is pulsed high. A single high sample restarts the low-run count.
- R8: While brk_det_en=1, neither rx_ready nor frame_err sets.
- R9: rx_active sets when a start edge is sampled. It clears after the receiver is idle and the line is high for (1 + data bits + stop bits) x 16 consecutive sample ticks.
- R10: After reset, rx_ready, frame_err, brk_flag, rx_active, bit9_out and data_out are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits |
| two_stop | input | 1 | 1 selects two stop bits |
| brk_det_en | input | 1 | Enables break detection and holds off data flags |
| data_rd | input | 1 | Read strobe for the data byte |
| brk_clr | input | 1 | Write-one clear of brk_flag |
| data_out | output | 8 | Buffered low eight data bits |
| bit9_out | output | 1 | Buffered ninth data bit |
| rx_ready | output | 1 | Buffer holds an unread character |
| frame_err | output | 1 | A stop bit was received low |
| brk_flag | output | 1 | Break character detected |
| rx_active | output | 1 | Receiver busy or line not yet idle |

## Verification
The bench sends a short low pulse that looks like a start edge. A receiver that skipped the start-bit vote would then assemble a garbage character and raise the ready flag. It also plants a one-tick glitch in a data bit, which a receiver using a single sample would copy into the byte. For each of the four formats, the bench holds the line low for half a bit time less and half a bit time more than the break threshold. This catches a threshold that ignores the format or is off by a bit. It also splits a long low run with one high bit, which a counter that never restarts would report as a break. Finally, the bench sends a second character before the first is read, and sends a bad stop bit after a good one. A buffer that overwrites unread data, or that loads on a framing error, would then show the wrong byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  // two-of-three vote
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // bit times in one character: start + data + stop
  function automatic int unsigned char_bits(input logic nine, input logic two);
    return 1 + (nine ? 9 : 8) + (two ? 2 : 1);
  endfunction

  // bit times of low needed to report a break
  function automatic int unsigned break_bits(input logic nine, input logic two);
    return 11 + (nine ? 1 : 0) + (two ? 1 : 0);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{1'b1}};
    else        sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int CNT_W = $clog2(OSR)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic       nine,
  input  logic       two,
  output logic       done,
  output logic       stop_ok,
  output logic [8:0] frame_data,
  output logic       start_seen,
  output logic       in_idle
);
  localparam int MID = OSR / 2;

  rx_state_e        state;
  logic [CNT_W-1:0] s_cnt;
  logic             va, vb;
  logic [3:0]       bidx;
  logic             sidx;
  logic             stop_bad;
  logic [8:0]       sh;
  logic             nine_q, two_q;

  logic vote, at_mid, at_end, last_bit;

  assign vote     = maj3(va, vb, rx);
  assign at_mid   = (s_cnt == CNT_W'(MID));
  assign at_end   = (s_cnt == CNT_W'(OSR - 1));
  assign last_bit = (bidx == (nine_q ? 4'd8 : 4'd7));

  assign in_idle    = (state == ST_IDLE);
  assign start_seen = tick && in_idle && !rx;
  assign done       = tick && (state == ST_STOP) && at_end && (sidx == two_q);
  assign stop_ok    = !stop_bad;
  assign frame_data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      s_cnt    <= '0;
      va       <= 1'b1;
      vb       <= 1'b1;
      bidx     <= '0;
      sidx     <= 1'b0;
      stop_bad <= 1'b0;
      sh       <= '0;
      nine_q   <= 1'b0;
      two_q    <= 1'b0;
    end else if (tick) begin
      if (s_cnt == CNT_W'(MID - 2)) va <= rx;
      if (s_cnt == CNT_W'(MID - 1)) vb <= rx;
      s_cnt <= s_cnt + CNT_W'(1);
      case (state)
        ST_IDLE: begin
          s_cnt <= '0;
          if (!rx) begin
            state  <= ST_START;
            s_cnt  <= CNT_W'(1);
            sh     <= '0;
            nine_q <= nine;
            two_q  <= two;
          end
        end
        ST_START: begin
          if (at_mid && vote) begin
            state <= ST_IDLE;
            s_cnt <= '0;
          end else if (at_end) begin
            state <= ST_DATA;
            s_cnt <= '0;
            bidx  <= '0;
          end
        end
        ST_DATA: begin
          if (at_mid) sh[bidx] <= vote;
          if (at_end) begin
            s_cnt <= '0;
            if (last_bit) begin
              state    <= ST_STOP;
              sidx     <= 1'b0;
              stop_bad <= 1'b0;
            end else begin
              bidx <= bidx + 4'd1;
            end
          end
        end
        ST_STOP: begin
          if (at_mid && !vote) stop_bad <= 1'b1;
          if (at_end) begin
            s_cnt <= '0;
            if (sidx == two_q) state <= ST_IDLE;
            else               sidx  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_break.sv
module rx_break #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx,
  input  logic             en,
  input  logic [CNT_W-1:0] thr,
  output logic             hit
);
  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (tick) begin
      if (!en || rx)          low_cnt <= '0;
      else if (low_cnt < thr) low_cnt <= low_cnt + CNT_W'(1);
    end
  end

  assign hit = tick && en && !rx && (low_cnt == thr - CNT_W'(1));
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rxd,
  input  logic       nine_bit,
  input  logic       two_stop,
  input  logic       brk_det_en,
  input  logic       data_rd,
  input  logic       brk_clr,
  output logic [7:0] data_out,
  output logic       bit9_out,
  output logic       rx_ready,
  output logic       frame_err,
  output logic       brk_flag,
  output logic       rx_active
);
  localparam int CNT_W  = $clog2(OSR);
  localparam int IDLE_W = $clog2(12 * OSR + 1);
  localparam int BRK_W  = $clog2(13 * OSR + 1);

  logic       rx_s;
  logic       done, stop_ok, start_seen, in_idle;
  logic [8:0] frame_data;
  logic       brk_hit;
  logic       frame_ok, frame_bad, load_buf;
  logic       line_quiet, idle_reached;
  logic [IDLE_W-1:0] idle_cnt, idle_target;
  logic [BRK_W-1:0]  brk_thr;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  rx_frame #(.OSR(OSR), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx(rx_s),
    .nine(nine_bit), .two(two_stop), .done(done), .stop_ok(stop_ok),
    .frame_data(frame_data), .start_seen(start_seen), .in_idle(in_idle)
  );

  assign brk_thr = BRK_W'(break_bits(nine_bit, two_stop) * OSR);

  rx_break #(.CNT_W(BRK_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx(rx_s),
    .en(brk_det_en), .thr(brk_thr), .hit(brk_hit)
  );

  assign frame_ok  = done && stop_ok && !brk_det_en;
  assign frame_bad = done && !stop_ok && !brk_det_en;
  assign load_buf  = frame_ok && (!rx_ready || data_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready  <= 1'b0;
      frame_err <= 1'b0;
      brk_flag  <= 1'b0;
      data_out  <= '0;
      bit9_out  <= 1'b0;
    end else begin
      if (load_buf) begin
        data_out <= frame_data[7:0];
        bit9_out <= frame_data[8];
      end
      if (frame_ok)     rx_ready <= 1'b1;
      else if (data_rd) rx_ready <= 1'b0;
      if (frame_bad)    frame_err <= 1'b1;
      else if (data_rd) frame_err <= 1'b0;
      if (brk_hit)      brk_flag <= 1'b1;
      else if (brk_clr) brk_flag <= 1'b0;
    end
  end

  // idle-line timer for the activity flag
  assign idle_target  = IDLE_W'(char_bits(nine_bit, two_stop) * OSR);
  assign line_quiet   = in_idle && rx_s;
  assign idle_reached = sample_tick && line_quiet && (idle_cnt == idle_target - IDLE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      rx_active <= 1'b0;
    end else begin
      if (sample_tick) begin
        if (!line_quiet)                idle_cnt <= '0;
        else if (idle_cnt < idle_target) idle_cnt <= idle_cnt + IDLE_W'(1);
      end
      if (start_seen)        rx_active <= 1'b1;
      else if (idle_reached) rx_active <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_det_en,
  input logic       data_rd,
  input logic       brk_clr,
  input logic [7:0] data_out,
  input logic       bit9_out,
  input logic       rx_ready,
  input logic       frame_err,
  input logic       brk_flag,
  input logic       rx_active,
  input logic       frame_ok,
  input logic       frame_bad,
  input logic       brk_hit,
  input logic       start_seen,
  input logic       idle_reached
);
  assert_no_ready_in_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> !$past(brk_det_en));

  assert_no_fe_in_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !$past(brk_det_en));

  assert_keep_unread_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && $past(rx_ready) && !$past(data_rd)) |-> ($stable(data_out) && $stable(bit9_out)));

  assert_read_clears_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !frame_ok) |=> !rx_ready);

  assert_read_clears_fe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !frame_bad) |=> !frame_err);

  assert_brk_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(brk_hit));

  assert_brk_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !brk_clr) |=> brk_flag);

  assert_active_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(start_seen));

  assert_active_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active) |-> $past(idle_reached));
endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brk_det_en(brk_det_en), .data_rd(data_rd),
  .brk_clr(brk_clr), .data_out(data_out), .bit9_out(bit9_out),
  .rx_ready(rx_ready), .frame_err(frame_err), .brk_flag(brk_flag),
  .rx_active(rx_active), .frame_ok(frame_ok), .frame_bad(frame_bad),
  .brk_hit(brk_hit), .start_seen(start_seen), .idle_reached(idle_reached)
);

// File: tb/tb_uart_rx_brk.sv
module tb_uart_rx_brk;
  localparam int TPS = 4;   // clocks per sample tick

  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0, rxd = 1'b1;
  logic nine_bit = 1'b0, two_stop = 1'b0, brk_det_en = 1'b0;
  logic data_rd = 1'b0, brk_clr = 1'b0;
  logic [7:0] data_out;
  logic bit9_out, rx_ready, frame_err, brk_flag, rx_active;

  int n_chk = 0, n_bad = 0;
  logic [8:0] last_buf = 9'h000;

  uart_rx_brk dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .nine_bit(nine_bit), .two_stop(two_stop), .brk_det_en(brk_det_en),
    .data_rd(data_rd), .brk_clr(brk_clr), .data_out(data_out),
    .bit9_out(bit9_out), .rx_ready(rx_ready), .frame_err(frame_err),
    .brk_flag(brk_flag), .rx_active(rx_active)
  );

  always #10 clk = ~clk;

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      sample_tick = (ph == 0);
      ph = (ph + 1) % TPS;
    end
  end

  function automatic int exp_break_ticks(input bit nine, input bit two);
    case ({nine, two})
      2'b00:          return 176;
      2'b01, 2'b10:   return 192;
      default:        return 208;
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int ticks);
    rxd = v;
    repeat (ticks * TPS) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit nine, input bit two,
                      input bit bad, input int glitch);
    int nb = nine ? 9 : 8;
    int total = 1 + nb + (two ? 2 : 1);
    for (int i = 0; i < total; i++) begin
      logic v;
      if (i == 0)            v = 1'b0;
      else if (i <= nb)      v = d[i-1];
      else if (i == nb + 1)  v = !bad;
      else                   v = 1'b1;
      if (i == glitch) begin
        hold(v, 7); hold(!v, 1); hold(v, 8);
      end else begin
        hold(v, 16);
      end
    end
    rxd = 1'b1;
  endtask

  task automatic rd_pulse();
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr_pulse();
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    @(negedge clk);
  endtask

  // good frame: send, wait, check buffer and flags, then read
  task automatic good_frame(input string req, input logic [8:0] d, input bit nine,
                            input bit two, input int glitch);
    logic [8:0] e = nine ? d : {1'b0, d[7:0]};
    nine_bit = nine; two_stop = two;
    send(d, nine, two, 1'b0, glitch);
    hold(1'b1, 32);
    chk({req, " ready"}, rx_ready, 1);
    chk({req, " data"}, {bit9_out, data_out}, e);
    last_buf = e;
    rd_pulse();
    chk("R4 ready cleared by read", rx_ready, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (5) @(negedge clk);
    chk("R10 reset outputs", {data_out, bit9_out, rx_ready, frame_err, brk_flag, rx_active}, 0);
    rst_n = 1'b1;
    hold(1'b1, 40);
    chk("R10 after reset idle", {rx_ready, frame_err, brk_flag, rx_active}, 0);

    good_frame("R1 8N1", 9'h0A5, 1'b0, 1'b0, -1);
    good_frame("R1 9-bit 2 stop", 9'h1C3, 1'b1, 1'b1, -1);
    good_frame("R1 9-bit ninth zero", 9'h07E, 1'b1, 1'b0, -1);
    good_frame("R2 glitch in data bit", 9'h05A, 1'b0, 1'b0, 3);
    good_frame("R2 glitch in start bit", 9'h1F0, 1'b1, 1'b0, 0);

    // noise on the line: short low pulse
    nine_bit = 0; two_stop = 0;
    hold(1'b0, 4); hold(1'b1, 20);
    chk("R9 active on start edge", rx_active, 1);
    hold(1'b1, 200);
    chk("R2 noise start gives no ready", rx_ready, 0);
    chk("R2 noise start gives no fe", frame_err, 0);
    chk("R9 active clears after idle", rx_active, 0);

    // idle timing after a real frame
    send(9'h033, 1'b0, 1'b0, 1'b0, -1);
    hold(1'b1, 32);
    chk("R9 active held before idle time", rx_active, 1);
    hold(1'b1, 200);
    chk("R9 active cleared after frame time", rx_active, 0);
    chk("R1 data 33", {bit9_out, data_out}, 9'h033);
    last_buf = 9'h033;
    rd_pulse();

    // framing error keeps buffer
    send(9'h077, 1'b0, 1'b1, 1'b1, -1);
    hold(1'b1, 32);
    chk("R3 fe set", frame_err, 1);
    chk("R3 ready not set", rx_ready, 0);
    chk("R3 buffer unchanged", {bit9_out, data_out}, last_buf);
    rd_pulse();
    chk("R4 fe cleared by read", frame_err, 0);

    // overrun: second frame does not replace unread data
    nine_bit = 1; two_stop = 0;
    send(9'h112, 1'b1, 1'b0, 1'b0, -1);
    hold(1'b1, 32);
    send(9'h0EE, 1'b1, 1'b0, 1'b0, -1);
    hold(1'b1, 32);
    chk("R5 ready still set", rx_ready, 1);
    chk("R5 old data kept", {bit9_out, data_out}, 9'h112);
    last_buf = 9'h112;
    rd_pulse();
    good_frame("R5 next frame loads", 9'h0EE, 1'b1, 1'b0, -1);

    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [8:0] d = 9'($urandom);
      bit nine = 1'($urandom);
      bit two = 1'($urandom);
      bit bad = ($urandom % 4) == 0;
      if (!bad) begin
        good_frame("R1 random", d, nine, two, -1);
      end else begin
        nine_bit = nine; two_stop = two;
        send(d, nine, two, 1'b1, -1);
        hold(1'b1, 32);
        chk("R3 random fe", {frame_err, rx_ready}, 2'b10);
        chk("R3 random buffer kept", {bit9_out, data_out}, last_buf);
        rd_pulse();
        chk("R4 random fe cleared", frame_err, 0);
      end
    end

    // break detection on: data flags held off
    brk_det_en = 1;
    nine_bit = 0; two_stop = 0;
    send(9'h055, 1'b0, 1'b0, 1'b0, -1);
    hold(1'b1, 32);
    chk("R8 no ready in break mode", rx_ready, 0);
    send(9'h055, 1'b0, 1'b0, 1'b1, -1);
    hold(1'b1, 32);
    chk("R8 no fe in break mode", frame_err, 0);

    // thresholds for each format
    for (int f = 0; f < 4; f++) begin
      bit nine = f[1];
      bit two = f[0];
      int thr = exp_break_ticks(nine, two);
      nine_bit = nine; two_stop = two;
      hold(1'b0, thr - 8); hold(1'b1, 320);
      chk("R6 short low no break", brk_flag, 0);
      hold(1'b0, thr + 8); hold(1'b1, 320);
      chk("R6 long low break", brk_flag, 1);
      chk("R8 flags held during break", {rx_ready, frame_err}, 0);
      hold(1'b1, 40);
      chk("R7 break sticky", brk_flag, 1);
      clr_pulse();
      chk("R7 break cleared", brk_flag, 0);
    end

    // low run split by one high bit
    nine_bit = 0; two_stop = 0;
    hold(1'b0, 176 - 24); hold(1'b1, 16); hold(1'b0, 176 - 24); hold(1'b1, 320);
    chk("R7 high sample restarts count", brk_flag, 0);

    // break detection off: no flag
    brk_det_en = 0;
    hold(1'b0, 240); hold(1'b1, 400);
    chk("R6 disabled no break", brk_flag, 0);
    rd_pulse();
    hold(1'b1, 40);

    summary();
    $finish;
  end
endmodule